// File: doc/BRIEF.md
# CAN Fault-Confinement State Classifier

This block sits next to a CAN protocol engine and turns its raw error indications into a fault-confinement state and a stream of event records. On each sample strobe it reads an error-flag byte, a status byte, a bus-error interrupt indication and the transmit and receive error counters. It computes the node's state (error-active, error-warning, error-passive or bus-off) by a fixed priority. When the state changes it issues a one-cycle state-change record that carries the new state, the direction blamed for it and a counter snapshot. When a protocol error is flagged and reporting is enabled, it issues a one-cycle bus-error record that names a single error type.

Bus-off is sticky. Once it is entered, later samples are ignored until a restart input brings the node back to error-active. A saturating counter tallies the bus-error records that have been issued. When one sample produces both kinds of record, the state-change record comes first and the bus-error record follows on the next cycle.

Top module: `can_fault_classifier`

## Requirements
- R1: After reset the state is error-active (code 0), the bus-off flag is low, both event strobes are low and the bus-error count is 0.
- R2: State codes are active=0, warning=1, passive=2, bus-off=3. A sample classifies as follows, in priority order: bus-off if flag bit 7 is set; otherwise passive if flag bit 6 or bit 5 is set; otherwise warning if status bit 4 is set; otherwise active. `state_o` shows the new state from the cycle after an accepted sample.
- R3: A state-change strobe rises for exactly one cycle, the cycle after an accepted sample, only when the classified state differs from the stored state. It carries the new state.
- R4: The change record's direction field has bit 0 (transmit) set when the transmit counter is at least the receive counter, and bit 1 (receive) set when the receive counter is at least the transmit counter. Equal counters set both bits.
- R5: A bus-error record is issued only when reporting is enabled, the bus-error interrupt input is high and flag bits 4..0 are not all zero. Bit 4 is a bit error, bit 3 a form error, bit 2 a CRC error, bit 1 an acknowledge error and bit 0 a stuff error. Exactly one type is reported, in the priority bit(code 1) > form(2) > stuff(3) > CRC(4) > acknowledge(5).
- R6: When one sample yields both records, the change strobe comes in the cycle after the sample and the bus-error strobe in the cycle after that. A bus-error record alone comes in the cycle after the sample. The two strobes are never high together.
- R7: Each accepted sample captures both counters. The snapshot outputs hold these values while either strobe of that sample is high.
- R8: Entering bus-off sets `busoff_o`. While it is set, samples are ignored: no records are issued and the state does not change. A restart pulse while bus-off returns the state to active and clears `busoff_o` without issuing any record. A restart at any other time has no effect.
- R9: The bus-error count rises by one, in the same cycle as each bus-error strobe, and saturates at its maximum value.
- R10: A sample that arrives in the cycle in which a deferred bus-error record is still pending is ignored. It changes neither the state nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Strobe: evaluate the inputs this cycle |
| err_flags_i | input | 8 | Error-flag byte (bus-off, passive, protocol errors) |
| status_i | input | 8 | Status byte; bit 4 is the warning indication |
| berr_irq_i | input | 1 | Bus-error interrupt is flagged |
| berr_rep_en_i | input | 1 | Bus-error reporting enable |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| restart_i | input | 1 | Leave bus-off and return to active |
| state_o | output | 2 | Current fault-confinement state |
| busoff_o | output | 1 | Sticky bus-off indication |
| chg_valid_o | output | 1 | State-change record strobe |
| chg_state_o | output | 2 | New state in the change record |
| chg_dir_o | output | 2 | Blamed direction: bit 0 transmit, bit 1 receive |
| berr_valid_o | output | 1 | Bus-error record strobe |
| berr_type_o | output | 3 | Selected protocol error type |
| snap_tec_o | output | CNT_W | Transmit counter snapshot |
| snap_rec_o | output | CNT_W | Receive counter snapshot |
| berr_count_o | output | BERR_CNT_W | Saturating count of bus-error records |

## Verification
The assertions take for granted that reset is held for at least one clock edge. They also assume that restart is only meaningful while bus-off, and place no limit on how often samples arrive. The bench holds the flag and status bytes, the interrupt, the enable and the counters stable from one falling edge to the next. It normally leaves two idle cycles after each sample, so that a deferred bus-error record can drain. One directed case breaks that spacing on purpose to show that a sample colliding with a pending record is dropped. The random stimulus keeps the bus-off flag rare, so that most samples land in the three non-sticky states, and it issues restarts both inside and outside bus-off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    typedef enum logic [2:0] {
        FC_ET_NONE  = 3'd0,
        FC_ET_BIT   = 3'd1,
        FC_ET_FORM  = 3'd2,
        FC_ET_STUFF = 3'd3,
        FC_ET_CRC   = 3'd4,
        FC_ET_ACK   = 3'd5
    } fc_etype_e;

    // Bit positions in the error-flag byte
    localparam int unsigned FLG_BUSOFF = 7;
    localparam int unsigned FLG_TXPASS = 6;
    localparam int unsigned FLG_RXPASS = 5;
    localparam int unsigned FLG_BIT    = 4;
    localparam int unsigned FLG_FORM   = 3;
    localparam int unsigned FLG_CRC    = 2;
    localparam int unsigned FLG_ACK    = 1;
    localparam int unsigned FLG_STUFF  = 0;
    // Bit position in the status byte
    localparam int unsigned STS_WARN   = 4;

    localparam logic [7:0] PROT_MASK   = 8'h1F;
    localparam int unsigned N_PROT     = 5;

    // Protocol error bits in reporting priority, highest first
    localparam int unsigned PROT_ORDER [N_PROT] =
        '{FLG_BIT, FLG_FORM, FLG_STUFF, FLG_CRC, FLG_ACK};

    typedef struct packed {
        fc_state_e  st;
        logic [1:0] dir;   // bit0 transmit, bit1 receive
    } fc_chg_t;

    function automatic logic any_prot(input logic [7:0] flags);
        return |(flags & PROT_MASK);
    endfunction

endpackage

// File: rtl/can_fc_state_decode.sv
module can_fc_state_decode
    import can_fc_pkg::*;
(
    input  logic [7:0] flags_i,
    input  logic [7:0] status_i,
    output fc_state_e  state_o
);
    always_comb begin
        if (flags_i[FLG_BUSOFF])
            state_o = FC_BUSOFF;
        else if (flags_i[FLG_TXPASS] || flags_i[FLG_RXPASS])
            state_o = FC_PASSIVE;
        else if (status_i[STS_WARN])
            state_o = FC_WARNING;
        else
            state_o = FC_ACTIVE;
    end
endmodule

// File: rtl/can_fc_err_select.sv
module can_fc_err_select
    import can_fc_pkg::*;
(
    input  logic [7:0] flags_i,
    output fc_etype_e  type_o,
    output logic       any_o
);
    always_comb begin
        type_o = FC_ET_NONE;
        // Walk from lowest to highest priority; the last hit wins
        for (int i = N_PROT - 1; i >= 0; i--) begin
            if (flags_i[PROT_ORDER[i]])
                type_o = fc_etype_e'(3'(i + 1));
        end
        any_o = any_prot(flags_i);
    end
endmodule

// File: rtl/can_fc_dir_attr.sv
module can_fc_dir_attr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    output logic [1:0]       dir_o
);
    assign dir_o[0] = (tec_i >= rec_i);
    assign dir_o[1] = (rec_i >= tec_i);
endmodule

// File: rtl/can_fc_satcnt.sv
module can_fc_satcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (inc_i && cnt_o != CMAX)
            cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/can_fault_classifier.sv
module can_fault_classifier
    import can_fc_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned BERR_CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_i,
    input  logic [7:0]            err_flags_i,
    input  logic [7:0]            status_i,
    input  logic                  berr_irq_i,
    input  logic                  berr_rep_en_i,
    input  logic [CNT_W-1:0]      tec_i,
    input  logic [CNT_W-1:0]      rec_i,
    input  logic                  restart_i,
    output logic [1:0]            state_o,
    output logic                  busoff_o,
    output logic                  chg_valid_o,
    output logic [1:0]            chg_state_o,
    output logic [1:0]            chg_dir_o,
    output logic                  berr_valid_o,
    output logic [2:0]            berr_type_o,
    output logic [CNT_W-1:0]      snap_tec_o,
    output logic [CNT_W-1:0]      snap_rec_o,
    output logic [BERR_CNT_W-1:0] berr_count_o
);
    fc_state_e  new_st;
    fc_etype_e  sel_type;
    logic       prot_any;
    logic [1:0] dir;

    can_fc_state_decode u_dec (
        .flags_i  (err_flags_i),
        .status_i (status_i),
        .state_o  (new_st)
    );

    can_fc_err_select u_sel (
        .flags_i (err_flags_i),
        .type_o  (sel_type),
        .any_o   (prot_any)
    );

    can_fc_dir_attr #(.CNT_W(CNT_W)) u_dir (
        .tec_i (tec_i),
        .rec_i (rec_i),
        .dir_o (dir)
    );

    fc_state_e        state_q;
    logic             busoff_q;
    logic             chg_valid_q;
    fc_chg_t          chg_q;
    logic             berr_valid_q;
    fc_etype_e        berr_type_q;
    logic             pend_q;
    logic [CNT_W-1:0] snap_tec_q;
    logic [CNT_W-1:0] snap_rec_q;

    logic accept, chg_now, be_now, berr_issue;

    always_comb begin
        accept     = sample_i && !busoff_q && !pend_q;
        chg_now    = accept && (new_st != state_q);
        be_now     = accept && berr_rep_en_i && berr_irq_i && prot_any;
        berr_issue = (be_now && !chg_now) || pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= FC_ACTIVE;
            busoff_q     <= 1'b0;
            chg_valid_q  <= 1'b0;
            chg_q        <= '{st: FC_ACTIVE, dir: 2'b00};
            berr_valid_q <= 1'b0;
            berr_type_q  <= FC_ET_NONE;
            pend_q       <= 1'b0;
            snap_tec_q   <= '0;
            snap_rec_q   <= '0;
        end else begin
            chg_valid_q  <= chg_now;
            berr_valid_q <= berr_issue;
            pend_q       <= be_now && chg_now;
            if (be_now)
                berr_type_q <= sel_type;
            if (accept) begin
                snap_tec_q <= tec_i;
                snap_rec_q <= rec_i;
            end
            if (chg_now) begin
                state_q   <= new_st;
                chg_q.st  <= new_st;
                chg_q.dir <= dir;
                if (new_st == FC_BUSOFF)
                    busoff_q <= 1'b1;
            end else if (restart_i && busoff_q) begin
                state_q  <= FC_ACTIVE;
                busoff_q <= 1'b0;
            end
        end
    end

    can_fc_satcnt #(.W(BERR_CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc_i (berr_issue),
        .cnt_o (berr_count_o)
    );

    assign state_o      = state_q;
    assign busoff_o     = busoff_q;
    assign chg_valid_o  = chg_valid_q;
    assign chg_state_o  = chg_q.st;
    assign chg_dir_o    = chg_q.dir;
    assign berr_valid_o = berr_valid_q;
    assign berr_type_o  = berr_type_q;
    assign snap_tec_o   = snap_tec_q;
    assign snap_rec_o   = snap_rec_q;
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned BERR_CNT_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sample_i,
    input logic                  restart_i,
    input logic [1:0]            state_o,
    input logic                  busoff_o,
    input logic                  chg_valid_o,
    input logic [1:0]            chg_state_o,
    input logic [1:0]            chg_dir_o,
    input logic                  berr_valid_o,
    input logic [2:0]            berr_type_o,
    input logic [BERR_CNT_W-1:0] berr_count_o
);
    localparam logic [BERR_CNT_W-1:0] CMAX = {BERR_CNT_W{1'b1}};

    // R6: the two strobes never coincide
    p_strobes_apart_r6: assert property (@(posedge clk) disable iff (rst)
        !(chg_valid_o && berr_valid_o));

    // R3: the change record matches the state it reports
    p_chg_matches_state_r3: assert property (@(posedge clk) disable iff (rst)
        chg_valid_o |-> (state_o == chg_state_o));

    // R3: a change strobe follows a sample
    p_chg_after_sample_r3: assert property (@(posedge clk) disable iff (rst)
        chg_valid_o |-> $past(sample_i));

    // R4: at least one direction is always blamed
    p_dir_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        chg_valid_o |-> (chg_dir_o != 2'b00));

    // R5: a bus-error record names a real type
    p_type_valid_r5: assert property (@(posedge clk) disable iff (rst)
        berr_valid_o |-> (berr_type_o >= 3'd1 && berr_type_o <= 3'd5));

    // R6: a bus-error strobe follows a sample or a change strobe
    p_berr_order_r6: assert property (@(posedge clk) disable iff (rst)
        berr_valid_o |-> ($past(sample_i) || $past(chg_valid_o)));

    // R8: bus-off persists without a restart
    p_busoff_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (busoff_o && !restart_i) |=> busoff_o);

    // R8: no change record while bus-off was already held
    p_no_chg_in_busoff_r8: assert property (@(posedge clk) disable iff (rst)
        (busoff_o && $past(busoff_o)) |-> !chg_valid_o);

    // R9: count steps by one per record, saturating
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        berr_valid_o |-> ((berr_count_o == $past(berr_count_o) + BERR_CNT_W'(1)) ||
                          (berr_count_o == CMAX && $past(berr_count_o) == CMAX)));

    // R9: count holds without a record
    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !berr_valid_o |-> $stable(berr_count_o));
endmodule

bind can_fault_classifier can_fc_checker #(
    .CNT_W      (CNT_W),
    .BERR_CNT_W (BERR_CNT_W)
) u_fc_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .restart_i    (restart_i),
    .state_o      (state_o),
    .busoff_o     (busoff_o),
    .chg_valid_o  (chg_valid_o),
    .chg_state_o  (chg_state_o),
    .chg_dir_o    (chg_dir_o),
    .berr_valid_o (berr_valid_o),
    .berr_type_o  (berr_type_o),
    .berr_count_o (berr_count_o)
);

// File: tb/tb_can_fault_classifier.sv
module tb_can_fault_classifier;
    localparam int CW = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_i = 1'b0;
    logic [7:0]    err_flags_i = '0;
    logic [7:0]    status_i = '0;
    logic          berr_irq_i = 1'b0;
    logic          berr_rep_en_i = 1'b0;
    logic [CW-1:0] tec_i = '0;
    logic [CW-1:0] rec_i = '0;
    logic          restart_i = 1'b0;
    logic [1:0]    state_o;
    logic          busoff_o;
    logic          chg_valid_o;
    logic [1:0]    chg_state_o;
    logic [1:0]    chg_dir_o;
    logic          berr_valid_o;
    logic [2:0]    berr_type_o;
    logic [CW-1:0] snap_tec_o;
    logic [CW-1:0] snap_rec_o;
    logic [BW-1:0] berr_count_o;

    can_fault_classifier #(.CNT_W(CW), .BERR_CNT_W(BW)) dut (.*);

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int m_state  = 0;
    bit m_busoff = 0;
    int m_cnt    = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cls(input logic [7:0] f, input logic [7:0] s);
        if (f[7]) return 3;
        if (f[6] || f[5]) return 2;
        if (s[4]) return 1;
        return 0;
    endfunction

    function automatic int etype(input logic [7:0] f);
        if (f[4]) return 1;
        if (f[3]) return 2;
        if (f[0]) return 3;
        if (f[2]) return 4;
        if (f[1]) return 5;
        return 0;
    endfunction

    task automatic berr_fields(input string req, input int et, input int t, input int r);
        chk(req, berr_valid_o, 1);
        chk(req, berr_type_o, et);
        chk("R9", berr_count_o, m_cnt);
        chk("R7", snap_tec_o, t);
        chk("R7", snap_rec_o, r);
    endtask

    // Starts and ends at a falling edge
    task automatic do_sample(input logic [7:0] f, input logic [7:0] s, input bit irq,
                             input bit en, input logic [CW-1:0] t, input logic [CW-1:0] r);
        int ns; bit chg; bit be;
        ns = cls(f, s);
        chg = !m_busoff && (ns != m_state);
        be  = !m_busoff && en && irq && ((f & 8'h1F) != 0);
        err_flags_i = f; status_i = s; berr_irq_i = irq; berr_rep_en_i = en;
        tec_i = t; rec_i = r; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        if (chg) begin
            m_state = ns;
            if (ns == 3) m_busoff = 1;
        end
        if (be && m_cnt < (1 << BW) - 1) m_cnt++;
        chk("R3", chg_valid_o, chg);
        if (chg) begin
            chk("R3", chg_state_o, ns);
            chk("R2", state_o, ns);
            chk("R4", chg_dir_o, {(r >= t), (t >= r)});
            chk("R7", snap_tec_o, t);
        end
        if (be && !chg) berr_fields("R5", etype(f), t, r);
        else chk("R6", berr_valid_o, 0);
        @(negedge clk);
        chk("R3", chg_valid_o, 0);
        if (be && chg) berr_fields("R6", etype(f), t, r);
        else chk("R6", berr_valid_o, 0);
        @(negedge clk);
        chk("R6", berr_valid_o, 0);
        chk("R2", state_o, m_state);
        chk("R8", busoff_o, m_busoff);
        chk("R9", berr_count_o, m_cnt);
    endtask

    task automatic do_restart();
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        if (m_busoff) begin m_busoff = 0; m_state = 0; end
        chk("R8", chg_valid_o, 0);
        chk("R8", state_o, m_state);
        chk("R8", busoff_o, m_busoff);
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", state_o, 0);
        chk("R1", busoff_o, 0);
        chk("R1", chg_valid_o, 0);
        chk("R1", berr_valid_o, 0);
        chk("R1", berr_count_o, 0);

        // R2 priority cases
        do_sample(8'h00, 8'h10, 0, 0, 8'd5, 8'd9);    // warning, rx blamed (R4)
        do_sample(8'h00, 8'h10, 0, 0, 8'd5, 8'd9);    // same state: no event (R3)
        do_sample(8'h40, 8'h10, 0, 0, 8'd20, 8'd20);  // passive over warning, equal counters (R4)
        do_sample(8'h20, 8'h00, 0, 0, 8'd30, 8'd2);   // rx passive flag, still passive
        do_sample(8'h00, 8'h00, 0, 0, 8'd1, 8'd0);    // back to active, tx blamed

        // R5 type priority, no state change
        do_sample(8'h1F, 8'h00, 1, 1, 8'd3, 8'd4);    // bit
        do_sample(8'h0F, 8'h00, 1, 1, 8'd3, 8'd4);    // form
        do_sample(8'h07, 8'h00, 1, 1, 8'd3, 8'd4);    // stuff over crc, ack
        do_sample(8'h06, 8'h00, 1, 1, 8'd3, 8'd4);    // crc over ack
        do_sample(8'h02, 8'h00, 1, 1, 8'd3, 8'd4);    // ack
        do_sample(8'h1F, 8'h00, 1, 0, 8'd3, 8'd4);    // reporting off
        do_sample(8'h1F, 8'h00, 0, 1, 8'd3, 8'd4);    // interrupt clear
        do_sample(8'h00, 8'h00, 1, 1, 8'd3, 8'd4);    // no protocol bit
        // R6 both from one sample
        do_sample(8'h48, 8'h00, 1, 1, 8'd50, 8'd7);

        // R8 bus-off, ignored samples, restart
        do_sample(8'h80, 8'h00, 0, 0, 8'd255, 8'd3);
        do_sample(8'h1F, 8'h10, 1, 1, 8'd1, 8'd1);    // ignored while bus-off
        do_restart();
        do_restart();                                  // ignored when not bus-off

        // R10 sample colliding with a pending record
        err_flags_i = 8'h50; status_i = 8'h00; berr_irq_i = 1; berr_rep_en_i = 1;
        tec_i = 8'd10; rec_i = 8'd5; sample_i = 1'b1;
        @(negedge clk);
        chk("R10", chg_valid_o, 1);
        chk("R10", state_o, 2);
        err_flags_i = 8'h00; status_i = 8'h10; tec_i = 8'd99; rec_i = 8'd98;
        @(negedge clk);
        sample_i = 1'b0;
        m_state = 2;
        if (m_cnt < (1 << BW) - 1) m_cnt++;
        chk("R10", chg_valid_o, 0);
        berr_fields("R10", 1, 10, 5);
        @(negedge clk);
        chk("R10", state_o, 2);
        chk("R10", chg_valid_o, 0);
        chk("R10", snap_tec_o, 10);
        @(negedge clk);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] f;
            logic [CW-1:0] t;
            logic [CW-1:0] r;
            f = 8'($urandom);
            if ($urandom % 10 != 0) f[7] = 1'b0;
            if ($urandom % 3 == 0) f[6:5] = 2'b00;
            t = CW'($urandom);
            r = ($urandom % 4 == 0) ? t : CW'($urandom);
            do_sample(f, 8'($urandom), 1'($urandom), ($urandom % 4 != 0), t, r);
            if (m_busoff ? ($urandom % 2 == 0) : ($urandom % 16 == 0))
                do_restart();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule